// File: doc/BRIEF.md
# Priority Selector with In-Service Tracking

This block sits between the pending-interrupt capture stage and the processor. Each cycle it receives a vector of already masked pending requests and a 4-bit priority for every source. It chooses the qualified request with the highest priority and places its source number and priority in a request register. The processor reads that register as the interrupt vector when it acknowledges.

Selection takes two clock cycles. The first register stage holds the raw selector result. The request register is the second stage. The request register does not update during an acknowledge cycle, so a higher-priority request that arrives late cannot change the vector that is being read.

An acknowledge marks the chosen source as in service and records its priority. An end-of-interrupt strobe sends the in-service set through the same selector. The highest-priority entry it finds is retired one cycle later. Because a stack of accepted interrupts is kept, nesting works. The interrupt line to the processor is raised only when the pending request is more urgent than every interrupt already in service.

Top module: `prio_svc_sel`

## Requirements
- R1: A change on the request inputs appears on the vector ID and priority outputs two rising edges later, and not after one. The outputs carry the qualified source with the highest priority. Source i takes its priority from bits [4i+3:4i] of the priority input.
- R2: A source whose priority is 0 is never chosen. When priorities are equal, the lower source index wins. With no qualified source, the ID output is the spurious code N_SRC (8 by default) and the priority output is 0.
- R3: During an acknowledge cycle the request register holds its value, and a request arriving in that cycle does not alter it.
- R4: When the request register holds a real source, an acknowledge sets that source's bit in the in-service mask output (bit i = source i) and stores its priority.
- R5: Two rising edges after an end-of-interrupt strobe, the in-service entry with the highest stored priority is cleared. Ties go to the lower index, and each strobe clears only one entry.
- R6: The request register keeps its value in the cycle when the end-of-interrupt lookup result is present, and afterwards follows the requests again.
- R7: The interrupt output is high only when the request register holds a source whose priority is strictly greater than the highest priority in service. An empty in-service set counts as priority 0.
- R8: An acknowledge while the ID output shows the spurious code sets no in-service bit.
- R9: An end-of-interrupt while nothing is in service leaves the in-service mask at zero and leaves the request register unchanged.
- R10: After reset the interrupt output is low, the ID is the spurious code, the priority is 0 and the in-service mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | N_SRC | Masked pending requests, one bit per source |
| prio_i | input | N_SRC*PRIO_W | Priority per source, source i at bits [PRIO_W*i +: PRIO_W] |
| ack_i | input | 1 | Interrupt acknowledge strobe, one cycle |
| eoi_i | input | 1 | End-of-interrupt strobe, one cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_id_o | output | ID_W | Source ID in the request register, N_SRC if spurious |
| vec_prio_o | output | PRIO_W | Priority in the request register |
| svc_mask_o | output | N_SRC | In-service bit per source |

## Verification
The assertions assume that acknowledge and end-of-interrupt never occur in the same cycle. They also assume that neither strobe occurs in the cycle after an end-of-interrupt, because the lookup and retirement of that strobe is still in progress. Under this rule the in-service mask changes by at most one entry per edge, and the spurious and empty cases can be checked without considering an overlapping clear. The bench meets the rule by pulsing each strobe for exactly one cycle and always leaving at least two idle cycles after an end-of-interrupt. Request and priority inputs change only on falling edges.

// File: rtl/psel_pkg.sv
// Package: shared definitions for the priority selector with in-service tracking.
// Assumes: priorities are unsigned; a larger value means more urgent.
package psel_pkg;

    // Default priority width; 0 is reserved for "source disabled".
    localparam int unsigned PSEL_PRIO_W = 4;

    // Selects which set of candidates drives the shared selector.
    typedef enum logic {
        PICK_PENDING = 1'b0,
        PICK_INSVC   = 1'b1
    } pick_src_e;

endpackage

// File: rtl/psel_pick.sv
// Module: psel_pick
// Combinational priority picker. It returns the candidate with the highest
// non-zero priority, and the lower index when priorities are equal.
// Assumes: SPUR_ID does not fit any real source index (SPUR_ID >= N).
module psel_pick #(
    parameter int unsigned N       = 8,
    parameter int unsigned PW      = 4,
    parameter int unsigned IW      = 4,
    parameter int unsigned SPUR_ID = 8
) (
    input  logic [N-1:0]    cand_i,
    input  logic [N*PW-1:0] prio_i,
    output logic            hit_o,
    output logic [IW-1:0]   id_o,
    output logic [PW-1:0]   prio_o
);

    logic [PW-1:0] best_p;
    logic [IW-1:0] best_i;

    // Linear scan: a strictly greater priority replaces the current best, so lower indices win ties.
    always_comb begin
        best_p = '0;
        best_i = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (cand_i[i] && (prio_i[i*PW +: PW] > best_p)) begin
                best_p = prio_i[i*PW +: PW];
                best_i = IW'(i);
            end
        end
    end

    // Output formatting: use the spurious code when nothing qualified.
    always_comb begin
        hit_o  = (best_p != '0);
        id_o   = hit_o ? best_i : IW'(SPUR_ID);
        prio_o = best_p;
    end

endmodule

// File: rtl/psel_svc.sv
// Module: psel_svc
// In-service record: one bit and one stored priority per source.
// Assumes: set and clear never name the same source in the same cycle
// (the environment keeps acknowledge away from end-of-interrupt); if they
// do, the set wins.
module psel_svc #(
    parameter int unsigned N  = 8,
    parameter int unsigned PW = 4,
    parameter int unsigned IW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en_i,
    input  logic [IW-1:0]   set_id_i,
    input  logic [PW-1:0]   set_prio_i,
    input  logic            clr_en_i,
    input  logic [IW-1:0]   clr_id_i,
    output logic [N-1:0]    svc_o,
    output logic [N*PW-1:0] svc_prio_o
);

    genvar g;
    generate
        for (g = 0; g < int'(N); g++) begin : g_entry
            logic          bit_q;
            logic [PW-1:0] prio_q;

            // Per-source entry: set on acknowledge, cleared on retirement.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q  <= 1'b0;
                    prio_q <= '0;
                end else if (set_en_i && (set_id_i == IW'(g))) begin
                    bit_q  <= 1'b1;
                    prio_q <= set_prio_i;
                end else if (clr_en_i && (clr_id_i == IW'(g))) begin
                    bit_q  <= 1'b0;
                    prio_q <= '0;
                end
            end

            assign svc_o[g]               = bit_q;
            assign svc_prio_o[g*PW +: PW] = prio_q;
        end
    endgenerate

endmodule

// File: rtl/psel_pipe.sv
// Module: psel_pipe
// Two-stage selection pipeline. Stage one records the raw picker result
// and whether that result was an in-service lookup. Stage two is the
// request register. It holds during acknowledge and while stage one
// carries a lookup result.
// Assumes: the picker result at the input is combinational from this cycle's candidates.
module psel_pipe #(
    parameter int unsigned PW      = 4,
    parameter int unsigned IW      = 4,
    parameter int unsigned SPUR_ID = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hit_i,
    input  logic [IW-1:0]             id_i,
    input  logic [PW-1:0]             prio_i,
    input  psel_pkg::pick_src_e       src_i,
    input  logic                      ack_i,
    output logic                      s1_hit_o,
    output logic [IW-1:0]             s1_id_o,
    output logic                      s1_svc_o,
    output logic                      rq_hit_o,
    output logic [IW-1:0]             rq_id_o,
    output logic [PW-1:0]             rq_prio_o
);

    logic                s1_hit_q;
    logic [IW-1:0]       s1_id_q;
    logic [PW-1:0]       s1_prio_q;
    psel_pkg::pick_src_e s1_src_q;

    logic                rq_hit_q;
    logic [IW-1:0]       rq_id_q;
    logic [PW-1:0]       rq_prio_q;
    logic                rq_load;

    // Stage one: capture the picker result on every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_hit_q  <= 1'b0;
            s1_id_q   <= IW'(SPUR_ID);
            s1_prio_q <= '0;
            s1_src_q  <= psel_pkg::PICK_PENDING;
        end else begin
            s1_hit_q  <= hit_i;
            s1_id_q   <= id_i;
            s1_prio_q <= prio_i;
            s1_src_q  <= src_i;
        end
    end

    // Load enable: freeze while the vector is read or while stage one is a lookup result.
    always_comb begin
        rq_load = !ack_i && (s1_src_q == psel_pkg::PICK_PENDING);
    end

    // Stage two: the request register that supplies the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_hit_q  <= 1'b0;
            rq_id_q   <= IW'(SPUR_ID);
            rq_prio_q <= '0;
        end else if (rq_load) begin
            rq_hit_q  <= s1_hit_q;
            rq_id_q   <= s1_id_q;
            rq_prio_q <= s1_prio_q;
        end
    end

    assign s1_hit_o  = s1_hit_q;
    assign s1_id_o   = s1_id_q;
    assign s1_svc_o  = (s1_src_q == psel_pkg::PICK_INSVC);
    assign rq_hit_o  = rq_hit_q;
    assign rq_id_o   = rq_id_q;
    assign rq_prio_o = rq_prio_q;

endmodule

// File: rtl/prio_svc_sel.sv
// Module: prio_svc_sel (top)
// Priority selector with in-service tracking. One picker serves both the
// pending requests and, during end-of-interrupt, the in-service set. A
// second picker finds the highest priority in service for interrupt gating.
// Assumes: acknowledge and end-of-interrupt are single-cycle strobes that
// never coincide. No strobe arrives in the cycle after end-of-interrupt.
module prio_svc_sel #(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned PRIO_W = psel_pkg::PSEL_PRIO_W,
    localparam int unsigned ID_W  = $clog2(N_SRC + 1),
    localparam int unsigned SPUR  = N_SRC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic                    ack_i,
    input  logic                    eoi_i,
    output logic                    irq_o,
    output logic [ID_W-1:0]         vec_id_o,
    output logic [PRIO_W-1:0]       vec_prio_o,
    output logic [N_SRC-1:0]        svc_mask_o
);

    logic [N_SRC-1:0]        svc_bits;
    logic [N_SRC*PRIO_W-1:0] svc_prio;

    psel_pkg::pick_src_e     pick_src;
    logic [N_SRC-1:0]        pick_cand;
    logic [N_SRC*PRIO_W-1:0] pick_prio;
    logic                    pick_hit;
    logic [ID_W-1:0]         pick_id;
    logic [PRIO_W-1:0]       pick_p;

    logic                    top_hit;
    logic [ID_W-1:0]         top_id;
    logic [PRIO_W-1:0]       top_svc_prio;

    logic                    s1_hit;
    logic [ID_W-1:0]         s1_id;
    logic                    s1_svc;
    logic                    rq_hit;
    logic [ID_W-1:0]         rq_id;
    logic [PRIO_W-1:0]       rq_prio;

    logic                    set_en;
    logic                    clr_en;

    // Candidate mux: end-of-interrupt sends the in-service set to the shared picker.
    always_comb begin
        pick_src  = eoi_i ? psel_pkg::PICK_INSVC : psel_pkg::PICK_PENDING;
        pick_cand = eoi_i ? svc_bits : pend_i;
        pick_prio = eoi_i ? svc_prio : prio_i;
    end

    psel_pick #(
        .N       (N_SRC),
        .PW      (PRIO_W),
        .IW      (ID_W),
        .SPUR_ID (SPUR)
    ) u_pick_main (
        .cand_i (pick_cand),
        .prio_i (pick_prio),
        .hit_o  (pick_hit),
        .id_o   (pick_id),
        .prio_o (pick_p)
    );

    psel_pick #(
        .N       (N_SRC),
        .PW      (PRIO_W),
        .IW      (ID_W),
        .SPUR_ID (SPUR)
    ) u_pick_svc (
        .cand_i (svc_bits),
        .prio_i (svc_prio),
        .hit_o  (top_hit),
        .id_o   (top_id),
        .prio_o (top_svc_prio)
    );

    psel_pipe #(
        .PW      (PRIO_W),
        .IW      (ID_W),
        .SPUR_ID (SPUR)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (pick_hit),
        .id_i      (pick_id),
        .prio_i    (pick_p),
        .src_i     (pick_src),
        .ack_i     (ack_i),
        .s1_hit_o  (s1_hit),
        .s1_id_o   (s1_id),
        .s1_svc_o  (s1_svc),
        .rq_hit_o  (rq_hit),
        .rq_id_o   (rq_id),
        .rq_prio_o (rq_prio)
    );

    // Record commands: acknowledge of a real source sets, a lookup result that found an entry clears.
    always_comb begin
        set_en = ack_i && rq_hit;
        clr_en = s1_svc && s1_hit;
    end

    psel_svc #(
        .N  (N_SRC),
        .PW (PRIO_W),
        .IW (ID_W)
    ) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en_i   (set_en),
        .set_id_i   (rq_id),
        .set_prio_i (rq_prio),
        .clr_en_i   (clr_en),
        .clr_id_i   (s1_id),
        .svc_o      (svc_bits),
        .svc_prio_o (svc_prio)
    );

    // Interrupt gating: the request must outrank everything already in service.
    always_comb begin
        irq_o = rq_hit && (rq_prio > (top_hit ? top_svc_prio : '0));
    end

    assign vec_id_o   = rq_id;
    assign vec_prio_o = rq_prio;
    assign svc_mask_o = svc_bits;

    logic unused_top_id;
    assign unused_top_id = ^top_id;

endmodule

// File: rtl/prio_svc_sel_chk.sv
// Module: prio_svc_sel_chk
// Port-level checker for prio_svc_sel, attached with bind below.
// Assumes: the environment keeps to the strobe spacing described in the top header.
module prio_svc_sel_chk #(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned ID_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              eoi_i,
    input logic              irq_o,
    input logic [ID_W-1:0]   vec_id_o,
    input logic [PRIO_W-1:0] vec_prio_o,
    input logic [N_SRC-1:0]  svc_mask_o
);

    logic [N_SRC-1:0] id_onehot;

    // Decode the presented ID so the in-service bit it should set can be located.
    always_comb begin
        id_onehot = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (vec_id_o == ID_W'(i)) id_onehot[i] = 1'b1;
        end
    end

    // environment rule: strobes never coincide
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && eoi_i));

    // environment rule: quiet cycle after end-of-interrupt
    eoi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> !ack_i && !eoi_i);

    // R2
    spur_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_prio_o == '0) == (vec_id_o == ID_W'(N_SRC)));

    // R3
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> $stable(vec_id_o) && $stable(vec_prio_o));

    // R4
    ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && (vec_prio_o != '0) |=> (svc_mask_o & $past(id_onehot)) != '0);

    // R5
    one_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(svc_mask_o) & ~svc_mask_o) <= 1);

    // R7
    irq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_prio_o != '0) && (id_onehot != '0));

    // R8
    spur_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && (vec_prio_o == '0) |=> svc_mask_o == $past(svc_mask_o));

    // R9
    empty_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i && (svc_mask_o == '0) |=> ##1 svc_mask_o == '0);

endmodule

bind prio_svc_sel prio_svc_sel_chk #(
    .N_SRC  (N_SRC),
    .PRIO_W (PRIO_W),
    .ID_W   (ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .eoi_i      (eoi_i),
    .irq_o      (irq_o),
    .vec_id_o   (vec_id_o),
    .vec_prio_o (vec_prio_o),
    .svc_mask_o (svc_mask_o)
);

// File: tb/prio_svc_sel_bench.sv
// Bench for prio_svc_sel: a vector table walk, then directed tests.
module prio_svc_sel_bench;

    localparam int N  = 8;
    localparam int PW = 4;
    localparam int IW = 4;
    localparam int SP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend = '0;
    logic [N*PW-1:0] prio = '0;
    logic          ack = 1'b0;
    logic          eoi = 1'b0;
    logic          irq;
    logic [IW-1:0] vid;
    logic [PW-1:0] vpr;
    logic [N-1:0]  svc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    prio_svc_sel u_prio_svc_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend),
        .prio_i     (prio),
        .ack_i      (ack),
        .eoi_i      (eoi),
        .irq_o      (irq),
        .vec_id_o   (vid),
        .vec_prio_o (vpr),
        .svc_mask_o (svc)
    );

    // {pend[8], prio[32], exp_id[4], exp_prio[4], exp_irq[1]}
    localparam logic [48:0] VEC [8] = '{
        {8'h00, 32'h11111111, 4'd8, 4'h0, 1'b0},
        {8'h01, 32'h00000003, 4'd0, 4'h3, 1'b1},
        {8'h0A, 32'h00009020, 4'd3, 4'h9, 1'b1},
        {8'h24, 32'h00700700, 4'd2, 4'h7, 1'b1},
        {8'h80, 32'h00000000, 4'd8, 4'h0, 1'b0},
        {8'hFF, 32'hF123456F, 4'd0, 4'hF, 1'b1},
        {8'hC0, 32'h04000000, 4'd6, 4'h4, 1'b1},
        {8'h10, 32'h000A0000, 4'd4, 4'hA, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 irq", 32'(irq), 0);
        check("R10 id", 32'(vid), SP);
        check("R10 prio", 32'(vpr), 0);
        check("R10 svc", 32'(svc), 0);

        // R1 R2 R7 table walk, nothing in service
        for (int v = 0; v < 8; v++) begin
            pend = VEC[v][48:41];
            prio = VEC[v][40:9];
            tick(2);
            check($sformatf("R1/R2 id vec%0d", v), 32'(vid), 32'(VEC[v][8:5]));
            check($sformatf("R1/R2 prio vec%0d", v), 32'(vpr), 32'(VEC[v][4:1]));
            check($sformatf("R7 irq vec%0d", v), 32'(irq), 32'(VEC[v][0]));
        end

        // R1 latency: not visible after one edge, visible after two
        pend = '0; tick(3);
        pend = 8'h02; prio = 32'h00000030;
        tick(1);
        check("R1 one edge id", 32'(vid), SP);
        tick(1);
        check("R1 two edges id", 32'(vid), 1);

        // R3 R4 acknowledge freezes vector while a higher request arrives
        ack = 1'b1; pend = 8'h22; prio = 32'h00900030;
        #1;
        check("R3 id during ack", 32'(vid), 1);
        tick(1);
        ack = 1'b0;
        check("R3 id held after ack", 32'(vid), 1);
        check("R4 svc after ack", 32'(svc), 32'h02);
        tick(1);
        check("R3 new id follows", 32'(vid), 5);
        check("R7 irq 9 over 3", 32'(irq), 1);
        ack = 1'b1; tick(1); ack = 1'b0;
        check("R4 nested svc", 32'(svc), 32'h22);

        // R7 strict comparison against in-service max 9
        pend = 8'h04; prio = 32'h00000900;
        tick(2);
        check("R7 equal prio no irq", 32'(irq), 0);
        prio = 32'h00000A00;
        tick(2);
        check("R7 higher prio irq", 32'(irq), 1);
        pend = '0; tick(2);

        // R5 retire highest in-service first, then the next
        eoi = 1'b1; tick(1); eoi = 1'b0;
        tick(1);
        check("R5 first retire", 32'(svc), 32'h02);
        tick(1);
        eoi = 1'b1; tick(1); eoi = 1'b0;
        tick(1);
        check("R5 second retire", 32'(svc), 32'h00);
        tick(1);

        // R8 spurious acknowledge
        check("R8 id spurious", 32'(vid), SP);
        ack = 1'b1; tick(1); ack = 1'b0;
        check("R8 svc unchanged", 32'(svc), 0);

        // R6 R9 empty end-of-interrupt leaves request register alone
        pend = 8'h10; prio = 32'h00020000;
        tick(2);
        check("R9 pre id", 32'(vid), 4);
        eoi = 1'b1; tick(1); eoi = 1'b0;
        tick(1);
        check("R6 id held in lookup cycle", 32'(vid), 4);
        check("R9 svc still empty", 32'(svc), 0);
        tick(1);
        check("R6 id after lookup", 32'(vid), 4);
        check("R6 prio after lookup", 32'(vpr), 2);

        // R5 tie among in-service entries: lower index retires first
        pend = 8'h08; prio = 32'h00006000;
        tick(2);
        ack = 1'b1; tick(1); ack = 1'b0;
        pend = 8'h40; prio = 32'h06000000;
        tick(2);
        check("R7 equal nested no irq", 32'(irq), 0);
        ack = 1'b1; tick(1); ack = 1'b0;
        pend = '0;
        check("R4 tie svc", 32'(svc), 32'h48);
        tick(2);
        eoi = 1'b1; tick(1); eoi = 1'b0;
        tick(1);
        check("R5 tie retire lower index", 32'(svc), 32'h40);
        tick(2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule